// File: doc/BRIEF.md
# Division Operand Initialisation Unit

This unit sets up the 64-bit working pair that an iterative divide-step sequence consumes. It also produces the divide overflow status. Each request carries a 32-bit dividend, a 32-bit divisor, a 3-bit mode code and the caller's current sticky-overflow bit. The mode selects signed or unsigned arithmetic and a quotient width of 32, 16 or 8 bits. For the narrow widths the dividend is pre-shifted left so that the remaining divide steps only have to produce the narrow quotient. For signed narrow requests whose operands have opposite signs, the vacated low bits are filled with ones.

The mode decides a single overflow flag, as follows:
- Unsigned modes flag a zero divisor.
- Signed modes also flag the one quotient that cannot be represented: the most negative dividend of the selected width divided by minus one.

The sticky flag returned is the incoming sticky bit ORed with the new overflow. The advance-overflow flag is always cleared. All results and flags appear one clock after the request through a single register stage.

Top module: `divinit_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Synchronous reset clears `out_valid`, `res_lo`, `res_hi`, `flag_v`, `flag_sv` and `flag_av`.
- R2: Mode 0 (signed word) gives `res_lo` = dividend and `res_hi` = the dividend's bit 31 copied into all 32 bits.
- R3: Mode 1 (unsigned word) gives `res_lo` = dividend and `res_hi` = 0.
- R4: Mode 2 (signed byte) places the 64-bit sign-extended dividend shifted left by 24 in {`res_hi`,`res_lo`}. When bit 31 of the dividend differs from bit 31 of the divisor, bits 23:0 of `res_lo` are forced to ones.
- R5: Mode 4 (signed halfword) is the same as R4 but with a shift of 16 and a ones fill of bits 15:0.
- R6: Mode 3 (unsigned byte) gives `res_lo` = dividend << 24 and `res_hi` = dividend >> 8. Mode 5 (unsigned halfword) gives `res_lo` = dividend << 16 and `res_hi` = dividend >> 16. Both shifts are logical.
- R7: In modes 0, 2 and 4, `flag_v` is set when the divisor is 0. It is also set when the divisor is 0xFFFFFFFF and the dividend equals 0x80000000 (mode 0), 0xFFFFFF80 (mode 2) or 0xFFFF8000 (mode 4). Otherwise `flag_v` is clear.
- R8: In modes 1, 3 and 5, `flag_v` is set exactly when the divisor is 0.
- R9: For modes 0 to 5, `flag_sv` = `sv_in` OR the new `flag_v`, and `flag_av` = 0.
- R10: Mode codes 6 and 7 give zero `res_lo` and `res_hi`. They leave `flag_v`, `flag_sv` and `flag_av` at their previous values, and `sv_in` has no effect.
- R11: In a cycle without `in_valid`, results and flags keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| dividend | input | 32 | Dividend operand |
| divisor | input | 32 | Divisor operand |
| mode | input | 3 | Mode code (0..5 valid) |
| sv_in | input | 1 | Current sticky-overflow bit |
| out_valid | output | 1 | Result strobe, one cycle after request |
| res_lo | output | 32 | Low word of the prepared pair |
| res_hi | output | 32 | High word of the prepared pair |
| flag_v | output | 1 | Divide overflow |
| flag_sv | output | 1 | Updated sticky overflow |
| flag_av | output | 1 | Advance overflow (cleared) |

## Verification
Every result and flag of a request is due exactly one rising edge after the edge that samples `in_valid`. No output is combinational from the inputs.

The bench drives each request on a falling edge and releases `in_valid` on the next falling edge. At that same falling edge it compares every output against its behavioural model, so exactly one register stage lies between stimulus and sample. It also runs idle cycles and unknown mode codes, and checks that the previously modelled values persist.

// File: rtl/divinit_pkg.sv
package divinit_pkg;

    localparam int DW     = 32;
    localparam int BYTE_Q = 8;
    localparam int HALF_Q = 16;
    localparam int QW     = $clog2(DW) + 2;

    typedef enum logic [2:0] {
        DM_SWORD = 3'd0,
        DM_UWORD = 3'd1,
        DM_SBYTE = 3'd2,
        DM_UBYTE = 3'd3,
        DM_SHALF = 3'd4,
        DM_UHALF = 3'd5
    } div_mode_e;

    typedef struct packed {
        logic          known;
        logic          is_signed;
        logic [QW-1:0] qbits;
    } mode_info_t;

    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
    } pair_t;

    function automatic mode_info_t decode_mode(input logic [2:0] m);
        mode_info_t info;
        info.known     = 1'b1;
        info.is_signed = 1'b0;
        info.qbits     = QW'(DW);
        case (m)
            DM_SWORD: info.is_signed = 1'b1;
            DM_UWORD: info.is_signed = 1'b0;
            DM_SBYTE: begin info.is_signed = 1'b1; info.qbits = QW'(BYTE_Q); end
            DM_UBYTE: info.qbits = QW'(BYTE_Q);
            DM_SHALF: begin info.is_signed = 1'b1; info.qbits = QW'(HALF_Q); end
            DM_UHALF: info.qbits = QW'(HALF_Q);
            default: begin
                info.known = 1'b0;
                info.qbits = '0;
            end
        endcase
        return info;
    endfunction

endpackage

// File: rtl/divinit_layout.sv
module divinit_layout
    import divinit_pkg::*;
(
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    input  mode_info_t    info,
    output pair_t         pair
);

    logic [2*DW-1:0] ext;
    logic [2*DW-1:0] shifted;
    logic [2*DW-1:0] fill;
    logic            opp_sign;

    always_comb begin
        ext      = info.is_signed ? {{DW{dividend[DW-1]}}, dividend}
                                  : {{DW{1'b0}}, dividend};
        shifted  = ext << (QW'(DW) - info.qbits);
        fill     = {{DW{1'b0}}, {DW{1'b1}}} >> info.qbits;
        opp_sign = info.is_signed & (dividend[DW-1] ^ divisor[DW-1]);
        pair     = pair_t'(opp_sign ? (shifted | fill) : shifted);
        if (!info.known) begin
            pair = '0;
        end
    end

endmodule

// File: rtl/divinit_ovf.sv
module divinit_ovf
    import divinit_pkg::*;
(
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    input  mode_info_t    info,
    output logic          ovf
);

    logic [DW-1:0] min_q;
    logic          div_zero;
    logic          div_m1;

    always_comb begin
        min_q    = {DW{1'b1}} << (info.qbits - QW'(1));
        div_zero = (divisor == '0);
        div_m1   = &divisor;
        ovf      = info.known &
                   (div_zero | (info.is_signed & div_m1 & (dividend == min_q)));
    end

endmodule

// File: rtl/divinit_unit.sv
module divinit_unit
    import divinit_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [31:0]   dividend,
    input  logic [31:0]   divisor,
    input  logic [2:0]    mode,
    input  logic          sv_in,
    output logic          out_valid,
    output logic [31:0]   res_lo,
    output logic [31:0]   res_hi,
    output logic          flag_v,
    output logic          flag_sv,
    output logic          flag_av
);

    mode_info_t info;
    pair_t      pair_nx;
    logic       ovf_nx;

    assign info = decode_mode(mode);

    divinit_layout u_layout (
        .dividend (dividend),
        .divisor  (divisor),
        .info     (info),
        .pair     (pair_nx)
    );

    divinit_ovf u_ovf (
        .dividend (dividend),
        .divisor  (divisor),
        .info     (info),
        .ovf      (ovf_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_lo    <= '0;
            res_hi    <= '0;
            flag_v    <= 1'b0;
            flag_sv   <= 1'b0;
            flag_av   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_lo <= pair_nx.lo;
                res_hi <= pair_nx.hi;
                if (info.known) begin
                    flag_v  <= ovf_nx;
                    flag_sv <= sv_in | ovf_nx;
                    flag_av <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/divinit_unit_chk.sv
module divinit_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] dividend,
    input logic [31:0] divisor,
    input logic [2:0]  mode,
    input logic        out_valid,
    input logic [31:0] res_lo,
    input logic [31:0] res_hi,
    input logic        flag_v,
    input logic        flag_sv,
    input logic        flag_av
);

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(res_lo) && $stable(res_hi) && $stable(flag_v)));

    // R9
    sticky_cover_chk: assert property (@(posedge clk) disable iff (rst)
        flag_v |-> flag_sv);

    // R9
    av_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_av);

    // R8
    zero_div_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode <= 3'd5 && divisor == 32'd0) |=> flag_v);

    // R3
    uword_layout_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 3'd1) |=> (res_hi == 32'd0 && res_lo == $past(dividend)));

    // R10
    unknown_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode >= 3'd6) |=> (res_lo == 32'd0 && res_hi == 32'd0 && $stable(flag_sv)));

endmodule

bind divinit_unit divinit_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .dividend  (dividend),
    .divisor   (divisor),
    .mode      (mode),
    .out_valid (out_valid),
    .res_lo    (res_lo),
    .res_hi    (res_hi),
    .flag_v    (flag_v),
    .flag_sv   (flag_sv),
    .flag_av   (flag_av)
);

// File: tb/divinit_unit_bench.sv
`timescale 1ns/1ps
module divinit_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic [2:0]  mode = '0;
    logic        sv_in = 1'b0;
    logic        out_valid;
    logic [31:0] res_lo, res_hi;
    logic        flag_v, flag_sv, flag_av;

    int nchk = 0;
    int nerr = 0;

    logic [31:0] e_lo = '0, e_hi = '0;
    logic        e_v = 1'b0, e_sv = 1'b0, e_av = 1'b0;

    always #4 clk = ~clk;

    divinit_unit u_divinit_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .dividend(dividend),
        .divisor(divisor), .mode(mode), .sv_in(sv_in), .out_valid(out_valid),
        .res_lo(res_lo), .res_hi(res_hi), .flag_v(flag_v), .flag_sv(flag_sv),
        .flag_av(flag_av)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model(input logic [31:0] d, input logic [31:0] dv,
                         input logic [2:0] m, input logic s);
        longint sd;
        logic [63:0] e;
        logic v;
        logic known;
        sd = longint'($signed(d));
        known = 1'b1;
        v = 1'b0;
        e = 64'd0;
        case (m)
            3'd0: begin e = sd; v = (dv == 0) || (dv == 32'hFFFFFFFF && d == 32'h80000000); end
            3'd1: begin e = {32'd0, d}; v = (dv == 0); end
            3'd2: begin
                e = sd <<< 24;
                if (d[31] != dv[31]) e = e | 64'hFFFFFF;
                v = (dv == 0) || (dv == 32'hFFFFFFFF && d == 32'hFFFFFF80);
            end
            3'd3: begin e = {d >> 8, d << 24}; v = (dv == 0); end
            3'd4: begin
                e = sd <<< 16;
                if (d[31] != dv[31]) e = e | 64'hFFFF;
                v = (dv == 0) || (dv == 32'hFFFFFFFF && d == 32'hFFFF8000);
            end
            3'd5: begin e = {d >> 16, d << 16}; v = (dv == 0); end
            default: known = 1'b0;
        endcase
        e_lo = e[31:0];
        e_hi = e[63:32];
        if (known) begin
            e_v  = v;
            e_sv = s | v;
            e_av = 1'b0;
        end
    endtask

    task automatic check_all(input string tag, input logic exp_valid);
        chk(tag, "out_valid", {63'd0, out_valid}, {63'd0, exp_valid});
        chk(tag, "res_lo", {32'd0, res_lo}, {32'd0, e_lo});
        chk(tag, "res_hi", {32'd0, res_hi}, {32'd0, e_hi});
        chk(tag, "flag_v", {63'd0, flag_v}, {63'd0, e_v});
        chk(tag, "flag_sv", {63'd0, flag_sv}, {63'd0, e_sv});
        chk(tag, "flag_av", {63'd0, flag_av}, {63'd0, e_av});
    endtask

    task automatic apply(input logic [31:0] d, input logic [31:0] dv,
                         input logic [2:0] m, input logic s, input string tag);
        @(negedge clk);
        dividend = d; divisor = dv; mode = m; sv_in = s; in_valid = 1'b1;
        model(d, dv, m, s);
        @(negedge clk);
        in_valid = 1'b0;
        check_all(tag, 1'b1);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        dividend = 32'hDEADBEEF; divisor = 32'd0; mode = 3'd0; sv_in = 1'b1;
        @(negedge clk);
        check_all(tag, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_all("R1", 1'b0);
        rst = 1'b0;
        // R2 signed word, positive and negative
        apply(32'h12345678, 32'h00000003, 3'd0, 1'b0, "R2");
        apply(32'h87654321, 32'h00000005, 3'd0, 1'b0, "R2");
        // R7 signed word overflow cases
        apply(32'h80000000, 32'hFFFFFFFF, 3'd0, 1'b0, "R7");
        apply(32'h00000010, 32'h00000000, 3'd0, 1'b0, "R7");
        // R3 unsigned word, R8 zero divisor
        apply(32'hCAFEF00D, 32'h00000007, 3'd1, 1'b1, "R3");
        apply(32'h80000000, 32'hFFFFFFFF, 3'd1, 1'b0, "R8");
        apply(32'h00000001, 32'h00000000, 3'd1, 1'b0, "R8");
        // R4 signed byte: fill, no fill, overflow
        apply(32'hFFFFFF85, 32'h00000005, 3'd2, 1'b0, "R4");
        apply(32'h0000007B, 32'h00000005, 3'd2, 1'b0, "R4");
        apply(32'h0000007B, 32'hFFFFFFFB, 3'd2, 1'b0, "R4");
        apply(32'hFFFFFF80, 32'hFFFFFFFF, 3'd2, 1'b0, "R7");
        apply(32'hFFFF8000, 32'hFFFFFFFF, 3'd2, 1'b0, "R7");
        // R5 signed halfword
        apply(32'hFFFF8123, 32'h00000100, 3'd4, 1'b0, "R5");
        apply(32'h00001234, 32'h00000010, 3'd4, 1'b0, "R5");
        apply(32'hFFFF8000, 32'hFFFFFFFF, 3'd4, 1'b0, "R7");
        apply(32'hFFFFFF80, 32'hFFFFFFFF, 3'd4, 1'b0, "R7");
        // R6 unsigned byte and halfword
        apply(32'hA1B2C3D4, 32'h00000009, 3'd3, 1'b0, "R6");
        apply(32'hA1B2C3D4, 32'h00000000, 3'd5, 1'b0, "R8");
        apply(32'h89ABCDEF, 32'hFFFFFFFF, 3'd5, 1'b0, "R6");
        // R9 sticky input with no overflow
        apply(32'h00000020, 32'h00000004, 3'd0, 1'b1, "R9");
        apply(32'h00000020, 32'h00000004, 3'd0, 1'b0, "R9");
        // R10 unknown modes: flags held, sv_in ignored
        apply(32'h00000001, 32'h00000000, 3'd0, 1'b0, "R10");
        apply(32'h12345678, 32'h00000000, 3'd6, 1'b0, "R10");
        apply(32'h00000020, 32'h00000004, 3'd1, 1'b0, "R10");
        apply(32'hFFFFFFFF, 32'h00000000, 3'd7, 1'b1, "R10");
        // R11 idle cycles hold results
        apply(32'h55AA55AA, 32'h00000003, 3'd3, 1'b1, "R11");
        idle("R11");
        idle("R11");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule